// File: doc/BRIEF.md
# Rate-Limited Descriptor Fetch Scheduler

This block decides, queue by queue, when a descriptor fetch toward a host-resident descriptor ring may be launched. Every queue holds a head index (the last descriptor already fetched) and receives a tail index (the last descriptor software has made valid), an enable flag, a ring size code and a minimum fetch spacing. A queue asks for service when it is enabled, its head differs from its tail, it has no fetch in flight, it carries no latched error, and enough time has passed since its last fetch.

Among the queues asking for service, a round-robin arbiter picks one. Its request (queue number, first index, descriptor count) is placed in an output register and held under a valid/ready handshake. A fetch never runs past the end of the ring. A fetch that would wrap is cut at the last ring slot, and the rest follows in a later request. The agent that performs the read reports completion with an error flag. On success the head moves to the last fetched slot. On failure the head stays put and the queue is blocked until a per-queue clear.

Spacing is counted in 2 ns ticks. A tick divider turns clock cycles into ticks (one tick per cycle by default). Each queue has its own saturating elapsed-tick counter.

Top module: `dfs_fetch_sched`

## Requirements
- R1: After reset no request is presented, every head index is 0 and every error flag is 0.
- R2: A queue requests a fetch only while its enable bit is 1, its head differs from its tail (both taken modulo ring depth), no fetch of its own is outstanding, and its error flag is 0; a disabled queue with pending descriptors produces no request.
- R3: A request carries start = (head + 1) mod depth and count = (tail − head) mod depth, for a ring of depth 2^size.
- R4: When start + count would exceed the ring depth, count is reduced to depth − start, so no request crosses the ring end; the remainder is requested afterwards starting at index 0.
- R5: A size code from 1 to 16 gives a depth of 2^size; any other code (0, or 17 and up) is treated as 1, a depth of 2.
- R6: A completion without error sets that queue's head to (start + count − 1) mod depth of its outstanding request.
- R7: A queue's elapsed counter restarts at 0 when its request is loaded and rises by one per tick, saturating. The queue is eligible again only once elapsed is strictly greater than its delay; a delay of 0 removes the gate. With one tick per cycle, the earliest next load comes delay + 2 cycles after the previous one.
- R8: A completion with error sets the queue's error flag and leaves its head unchanged; the flag stays set, and the queue issues no request, until it is cleared.
- R9: A clear pulse on a queue sets its head and error flag to 0 and makes its next fetch ungated by the delay.
- R10: When several queues are eligible, they are served in round-robin order, starting from the queue after the one granted most recently (queue 0 first after reset).
- R11: A presented request keeps its queue, start and count unchanged until it is accepted (valid and ready both 1 on a clock edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_enable | input | NQ | Per-queue enable |
| q_size | input | NQ×5 | Per-queue ring size code (log2 depth) |
| q_tail | input | NQ×16 | Per-queue tail index |
| q_delay | input | NQ×DLY_W | Per-queue minimum spacing, in ticks |
| q_clear | input | NQ | Per-queue clear pulse |
| req_valid | output | 1 | Fetch request present |
| req_ready | input | 1 | Fetch request accepted |
| req_queue | output | QID_W | Queue of the request |
| req_start | output | 16 | First descriptor index |
| req_count | output | 16 | Number of descriptors |
| cpl_valid | input | 1 | Fetch completion strobe |
| cpl_queue | input | QID_W | Queue of the completion |
| cpl_error | input | 1 | Completion ended in error |
| head_out | output | NQ×16 | Per-queue head index |
| err_out | output | NQ | Per-queue latched fetch error |

## Verification
The hardest state to reach is an exact spacing interval. The gap between two fetches of one queue depends on the delay, on when the bench returns the completion, and on when the new tail arrives. The stimulus raises the tail one cycle after the first handshake and completes each fetch one cycle after acceptance, so the second load is gated only by the elapsed counter. The gap between handshakes is then checked to be exactly delay + 2 cycles, and 3 cycles with the gate off. The round-robin case is reached by first granting one queue alone, so that the rotation pointer sits mid-range. Three queues are then made eligible in the same cycle.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam int PTR_W    = 16;
    localparam int SIZE_W   = 5;
    localparam int MAX_LOG2 = 16;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [PTR_W:0]    span_t;
    typedef logic [SIZE_W-1:0] size_t;

    typedef struct packed {
        ptr_t start;
        ptr_t count;
    } fetch_t;

    function automatic span_t ring_depth(size_t sz);
        logic legal;
        legal = (sz >= size_t'(1)) && (sz <= size_t'(MAX_LOG2));
        return span_t'(1) << (legal ? sz : size_t'(1));
    endfunction

    function automatic fetch_t plan_fetch(ptr_t head, ptr_t tail, span_t depth);
        span_t  mask;
        span_t  st;
        span_t  cnt;
        fetch_t f;
        mask = depth - span_t'(1);
        st   = (span_t'(head) + span_t'(1)) & mask;
        cnt  = (span_t'(tail) - span_t'(head)) & mask;
        if (st + cnt > depth)
            cnt = depth - st;
        f.start = ptr_t'(st);
        f.count = ptr_t'(cnt);
        return f;
    endfunction
endpackage

// File: rtl/dfs_tick_gen.sv
module dfs_tick_gen #(
    parameter int CLK_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/dfs_queue_ctx.sv
module dfs_queue_ctx
    import dfs_pkg::*;
#(
    parameter int DLY_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  size_t            size,
    input  ptr_t             tail,
    input  logic [DLY_W-1:0] delay,
    input  logic             clear,
    input  logic             tick,
    input  logic             load,
    input  logic             cpl_hit,
    input  logic             cpl_err,
    output logic             eligible,
    output fetch_t           plan,
    output ptr_t             head,
    output logic             err
);
    localparam logic [DLY_W:0] SAT = '1;

    logic           busy;
    logic [DLY_W:0] elapsed;
    ptr_t           count_r;
    span_t          depth;
    logic           spaced;

    assign depth  = ring_depth(size);
    assign plan   = plan_fetch(head, tail, depth);
    assign spaced = (delay == '0) || (elapsed > {1'b0, delay});
    assign eligible = enable && !err && !busy && spaced && (plan.count != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head    <= '0;
            err     <= 1'b0;
            busy    <= 1'b0;
            elapsed <= SAT;
            count_r <= '0;
        end else begin
            if (load) begin
                busy    <= 1'b1;
                elapsed <= '0;
                count_r <= plan.count;
            end else if (tick && elapsed != SAT) begin
                elapsed <= elapsed + 1'b1;
            end
            if (cpl_hit && busy) begin
                busy <= 1'b0;
                if (cpl_err) err  <= 1'b1;
                else         head <= ptr_t'((span_t'(head) + span_t'(count_r))
                                            & (depth - span_t'(1)));
            end
        end
    end
endmodule

// File: rtl/dfs_rr_arb.sv
module dfs_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] last;

    always_comb begin
        int c;
        any = 1'b0;
        idx = '0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(last) + k) % N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          last <= IW'(N - 1);
        else if (advance) last <= idx;
    end
endmodule

// File: rtl/dfs_fetch_sched.sv
module dfs_fetch_sched
    import dfs_pkg::*;
#(
    parameter int NQ           = 4,
    parameter int DLY_W        = 20,
    parameter int CLK_PER_TICK = 1,
    localparam int QID_W       = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NQ-1:0]              q_enable,
    input  logic [NQ-1:0][SIZE_W-1:0]  q_size,
    input  logic [NQ-1:0][PTR_W-1:0]   q_tail,
    input  logic [NQ-1:0][DLY_W-1:0]   q_delay,
    input  logic [NQ-1:0]              q_clear,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [QID_W-1:0]           req_queue,
    output logic [PTR_W-1:0]           req_start,
    output logic [PTR_W-1:0]           req_count,
    input  logic                       cpl_valid,
    input  logic [QID_W-1:0]           cpl_queue,
    input  logic                       cpl_error,
    output logic [NQ-1:0][PTR_W-1:0]   head_out,
    output logic [NQ-1:0]              err_out
);
    logic              tick;
    logic [NQ-1:0]     elig;
    logic [NQ-1:0]     load;
    fetch_t [NQ-1:0]   plans;
    logic              pick_any;
    logic [QID_W-1:0]  pick_idx;
    logic              take;

    assign take = !req_valid && pick_any;

    dfs_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) i_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign load[g] = take && (pick_idx == QID_W'(g));
        dfs_queue_ctx #(.DLY_W(DLY_W)) i_ctx (
            .clk     (clk),
            .rst     (rst),
            .enable  (q_enable[g]),
            .size    (q_size[g]),
            .tail    (q_tail[g]),
            .delay   (q_delay[g]),
            .clear   (q_clear[g]),
            .tick    (tick),
            .load    (load[g]),
            .cpl_hit (cpl_valid && cpl_queue == QID_W'(g)),
            .cpl_err (cpl_error),
            .eligible(elig[g]),
            .plan    (plans[g]),
            .head    (head_out[g]),
            .err     (err_out[g])
        );
    end

    dfs_rr_arb #(.N(NQ), .IW(QID_W)) i_arb (
        .clk(clk), .rst(rst), .req(elig), .advance(take),
        .any(pick_any), .idx(pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_queue <= '0;
            req_start <= '0;
            req_count <= '0;
        end else if (take) begin
            req_valid <= 1'b1;
            req_queue <= pick_idx;
            req_start <= plans[pick_idx].start;
            req_count <= plans[pick_idx].count;
        end else if (req_valid && req_ready) begin
            req_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dfs_fetch_sched_chk.sv
module dfs_fetch_sched_chk
    import dfs_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DLY_W = 20,
    parameter int QID_W = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NQ-1:0]              q_enable,
    input logic [NQ-1:0][SIZE_W-1:0]  q_size,
    input logic [NQ-1:0]              q_clear,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [QID_W-1:0]           req_queue,
    input logic [PTR_W-1:0]           req_start,
    input logic [PTR_W-1:0]           req_count,
    input logic                       cpl_valid,
    input logic [NQ-1:0][PTR_W-1:0]   head_out,
    input logic [NQ-1:0]              err_out
);
    logic [NQ-1:0] en_d;
    logic [NQ-1:0] err_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d  <= '0;
            err_d <= '0;
        end else begin
            en_d  <= q_enable;
            err_d <= err_out;
        end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_queue)
                                 && $stable(req_start) && $stable(req_count));

    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_count != '0);

    assert_inside_ring_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (span_t'(req_start) + span_t'(req_count)
                       <= ring_depth(q_size[req_queue])));

    assert_enabled_only_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> en_d[req_queue]);

    assert_blocked_on_err_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> !err_d[req_queue]);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err_out & ~q_clear) != '0 |=> ($past(err_out & ~q_clear) & ~err_out) == '0);

    assert_head_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !cpl_valid && q_clear == '0 |=> $stable(head_out));
endmodule

bind dfs_fetch_sched dfs_fetch_sched_chk #(.NQ(NQ), .DLY_W(DLY_W), .QID_W(QID_W)) i_chk (
    .clk(clk), .rst(rst), .q_enable(q_enable), .q_size(q_size), .q_clear(q_clear),
    .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
    .req_start(req_start), .req_count(req_count), .cpl_valid(cpl_valid),
    .head_out(head_out), .err_out(err_out)
);

// File: tb/test_dfs_fetch_sched.sv
module test_dfs_fetch_sched;
    localparam int NQ = 4;
    localparam int DW = 20;
    localparam int QW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NQ-1:0]          q_enable = '0;
    logic [NQ-1:0][4:0]     q_size   = '0;
    logic [NQ-1:0][15:0]    q_tail   = '0;
    logic [NQ-1:0][DW-1:0]  q_delay  = '0;
    logic [NQ-1:0]          q_clear  = '0;
    logic                   req_valid;
    logic                   req_ready = 1'b1;
    logic [QW-1:0]          req_queue;
    logic [15:0]            req_start;
    logic [15:0]            req_count;
    logic                   cpl_valid = 1'b0;
    logic [QW-1:0]          cpl_queue = '0;
    logic                   cpl_error = 1'b0;
    logic [NQ-1:0][15:0]    head_out;
    logic [NQ-1:0]          err_out;

    dfs_fetch_sched #(.NQ(NQ), .DLY_W(DW)) i_dfs_fetch_sched (.*);

    always #4 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int hs_count = 0;
    longint exp_q[$];
    int     exp_tag[$];
    int     hs_time[$];
    logic [NQ-1:0] inject_err = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint pack(int q, int st, int cnt);
        return (longint'(q) << 32) | (longint'(st) << 16) | longint'(cnt);
    endfunction

    task automatic expect_req(input int tag, input int q, input int st, input int cnt);
        exp_q.push_back(pack(q, st, cnt));
        exp_tag.push_back(tag);
    endtask

    // monitor: compares each accepted request, then completes it one cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && req_valid && req_ready) begin
                longint act;
                int tg;
                int qq;
                act = pack(int'(req_queue), int'(req_start), int'(req_count));
                qq  = int'(req_queue);
                hs_time.push_back(cyc);
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected request", act, 0);
                end else begin
                    tg = exp_tag.pop_front();
                    chk($sformatf("R%0d request", tg), act, exp_q.pop_front());
                end
                hs_count++;
                @(posedge clk); #2;
                cpl_valid = 1'b1;
                cpl_queue = QW'(qq);
                cpl_error = inject_err[qq];
                @(posedge clk); #2;
                cpl_valid = 1'b0;
                cpl_error = 1'b0;
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int n;
        int gap;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        q_size[0] = 5'd4; q_size[1] = 5'd3; q_size[2] = 5'd0; q_size[3] = 5'd4;
        repeat (3) @(negedge clk);
        chk("R1 req_valid", req_valid, 0);
        chk("R1 heads", head_out, 0);
        chk("R1 errs", err_out, 0);

        // R2: disabled queue with work stays silent
        @(posedge clk); #2 q_tail[0] = 16'd5;
        repeat (10) @(negedge clk);
        chk("R2 disabled no request", req_valid, 0);
        expect_req(3, 0, 1, 5);
        @(posedge clk); #2 q_enable[0] = 1'b1;
        drain();
        chk("R6 head after fetch", head_out[0], 5);

        // R3: plain fetch
        expect_req(3, 0, 6, 4);
        q_tail[0] = 16'd9;
        drain();
        chk("R6 head q0", head_out[0], 9);

        // R4: wrap in an 8-entry ring
        expect_req(3, 1, 1, 6);
        q_enable[1] = 1'b1; q_tail[1] = 16'd6;
        drain();
        chk("R6 head q1", head_out[1], 6);
        expect_req(4, 1, 7, 1);
        expect_req(4, 1, 0, 3);
        q_tail[1] = 16'd2;
        drain();
        chk("R4 head after wrap", head_out[1], 2);

        // R5: illegal size code treated as depth 2
        expect_req(5, 2, 1, 1);
        q_enable[2] = 1'b1; q_tail[2] = 16'd1;
        drain();
        chk("R5 head q2", head_out[2], 1);
        expect_req(5, 2, 0, 1);
        q_tail[2] = 16'd0;
        drain();
        chk("R5 head wraps q2", head_out[2], 0);

        // R7: spacing of 20 ticks
        q_delay[3] = 20'd20;
        expect_req(7, 3, 1, 2);
        expect_req(7, 3, 3, 2);
        n = hs_count;
        q_enable[3] = 1'b1; q_tail[3] = 16'd2;
        wait (hs_count == n + 1);
        @(posedge clk); #2 q_tail[3] = 16'd4;
        drain();
        gap = hs_time[hs_time.size()-1] - hs_time[hs_time.size()-2];
        chk("R7 gap delay 20", gap, 22);

        // R7: no gating at delay 0
        q_delay[3] = '0;
        expect_req(7, 3, 5, 2);
        expect_req(7, 3, 7, 2);
        n = hs_count;
        q_tail[3] = 16'd6;
        wait (hs_count == n + 1);
        @(posedge clk); #2 q_tail[3] = 16'd8;
        drain();
        gap = hs_time[hs_time.size()-1] - hs_time[hs_time.size()-2];
        chk("R7 gap delay 0", gap, 3);

        // R8: error completion latches and blocks
        inject_err[3] = 1'b1;
        expect_req(8, 3, 9, 2);
        q_tail[3] = 16'd10;
        drain();
        chk("R8 err set", err_out[3], 1);
        chk("R8 head kept", head_out[3], 8);
        n = hs_count;
        inject_err[3] = 1'b0;
        q_tail[3] = 16'd12;
        repeat (10) @(negedge clk);
        chk("R8 blocked", hs_count, n);
        chk("R8 err still set", err_out[3], 1);

        // R9: clear restarts the queue
        expect_req(9, 3, 1, 12);
        @(posedge clk); #2 q_clear[3] = 1'b1;
        @(posedge clk); #2 q_clear[3] = 1'b0;
        @(negedge clk);
        chk("R9 err cleared", err_out[3], 0);
        chk("R9 head cleared", head_out[3], 0);
        drain();
        chk("R9 head after refetch", head_out[3], 12);

        // R10: move rotation to queue 1, then three queues at once
        expect_req(10, 1, 3, 1);
        q_tail[1] = 16'd3;
        drain();
        expect_req(10, 2, 1, 1);
        expect_req(10, 0, 10, 3);
        expect_req(10, 1, 4, 2);
        q_tail[0] = 16'd12; q_tail[1] = 16'd5; q_tail[2] = 16'd1;
        drain();

        // R11: request held under backpressure
        req_ready = 1'b0;
        expect_req(11, 0, 13, 2);
        q_tail[0] = 16'd14;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11 held", pack(int'(req_queue), int'(req_start), int'(req_count))
                            | (longint'(req_valid) << 40),
                (longint'(1) << 40) | pack(0, 13, 2));
        end
        @(posedge clk); #2 req_ready = 1'b1;
        drain();
        chk("R11 accepted once", head_out[0], 14);

        chk("R10 all expected seen", exp_q.size(), 0);
        summary();
    end
endmodule